// File: doc/BRIEF.md
# SPI Burst Memory Access Engine

This block is the serial front end of a byte-wide memory of 128K locations. It acts as an SPI mode-0 slave. After chip-select falls it takes an 8-bit command. For array commands it then takes a 17-bit address in three bytes and moves data in bursts. The address steps up by one after every byte and wraps from the top of the array back to zero. The block also handles a few short control commands: setting and clearing the write latch, reading a status byte, and writing a status byte. The latch, the status bits and the protection decision belong to a separate protection controller. This block signals to that controller and asks it about each write.

All SPI pins are brought into the system clock domain through a synchroniser and edge detectors. The system clock must run at least 8 times faster than SCK. The memory port is a plain strobe interface with no back-pressure, because SCK cannot be stalled:
- `mem_re` and `mem_we` are one-cycle strobes, and `mem_addr` is valid with them.
- The memory must accept a strobe in any cycle.
- The memory must present the read byte on `mem_rdata` from the cycle after `mem_re`, and hold it until the next `mem_re`.

Permission is asked combinationally. `prot_addr` shows the target of the next write byte, and `wr_permit` must answer for that address in the same cycle.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, `spi_so_oe`, `mem_re`, `mem_we`, `wen_set`, `wen_clr` and `sr_wr` are all low.
- R2: Commands are received MSB first on SI on SCK rising edges, with these codes: 0x03 read, 0x02 write, 0x06 set write latch, 0x04 clear write latch, 0x05 status read, 0x01 status write. After 0x06, the chip-select rise produces one `wen_set` pulse. After 0x04, it produces one `wen_clr` pulse, and `spi_so_oe` stays low throughout that frame.
- R3: Read and write commands take three address bytes. Bit 0 of the first byte is address bit 16 and its other seven bits are ignored. The next two bytes carry bits 15..8 and then 7..0.
- R4: In a read, the first data bit (bit 7 of the addressed byte) is driven on SO after the first SCK falling edge that follows the last address bit. Later bits follow, MSB first, one per falling edge. SI is ignored in that phase. `spi_so_oe` is high only in read-data and status-read phases.
- R5: A read continues while chip-select stays low, with the address rising by one per byte. After 0x1FFFF the next address is 0x00000.
- R6: In a write, every complete byte after the address gives one `mem_we` pulse, with `mem_wdata` and `mem_addr` set to successive addresses. After 0x1FFFF the next address is 0x00000.
- R7: A write byte whose `wr_permit` is low at its completion produces no strobe, but the burst address still advances.
- R8: If `busy` is high when a read or write command byte completes, the whole frame is ignored: no `mem_re`, no `mem_we`, and SO stays disabled. A high `busy` also blocks the strobe of any single write byte.
- R9: Fewer than 8 bits received when chip-select rises are discarded, with no memory write.
- R10: An unknown command code produces no strobe, no pulse and no SO drive until chip-select rises.
- R11: A status read drives `status_in` repeatedly, one byte per 8 falling edges, sampling it again at the start of each byte. A status write gives one `sr_wr` pulse carrying the first complete byte, and later bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | SO output enable (high = drive, low = high impedance) |
| busy | input | 1 | Store or recall in progress; array commands refused |
| mem_addr | output | 17 | Memory address for the current strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, held from the cycle after `mem_re` |
| prot_addr | output | 17 | Target address of the next write byte |
| wr_permit | input | 1 | Permission for a write to `prot_addr` in this cycle |
| wen_set | output | 1 | One-cycle pulse that sets the write latch |
| wen_clr | output | 1 | One-cycle pulse that clears the write latch |
| status_in | input | 8 | Status byte to shift out |
| sr_wr | output | 1 | One-cycle status-write pulse |
| sr_wdata | output | 8 | Status byte received |

## Verification
Two functions meet in the same cycle when a write burst crosses the top of the array inside a protected quarter. The completion of the byte for 0x1FFFF must refuse the strobe and wrap the pointer to zero together, and the very next byte must then be accepted at address 0. The bench provokes this with a directed four-byte write starting at 0x1FFFE with the top quarter protected. It judges the result by the strobe count and by reading the four locations back. A second overlap is the sampling of `busy` in the cycle where the command byte completes. The bench holds `busy` high across that edge and expects no strobes and no SO drive for the whole frame.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_WRSR  = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OPC_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_WRDI  = 8'h04;
  localparam logic [BYTE_W-1:0] OPC_RDSR  = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_RDATA,
    PH_WDATA,
    PH_SRD,
    PH_SWR,
    PH_CMD,
    PH_SKIP
  } phase_t;

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic cs_end,
  output logic si_s
);

  logic [STAGES:0]   sck_q;
  logic [STAGES:0]   cs_q;
  logic [STAGES-1:0] si_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[STAGES-1:0], sck};
      cs_q  <= {cs_q[STAGES-1:0], cs_n};
      si_q  <= {si_q[STAGES-2:0], si};
    end
  end

  assign sck_rise  =  sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sck_fall  = ~sck_q[STAGES-1] &  sck_q[STAGES];
  assign cs_active = ~cs_q[STAGES-1];
  assign cs_end    =  cs_q[STAGES-1] & ~cs_q[STAGES];
  assign si_s      =  si_q[STAGES-1];

endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic         byte_done,
  output logic [W-1:0] byte_val
);

  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  assign byte_val  = {sh[W-2:0], bit_in};
  assign byte_done = shift && (cnt == CW'(W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift) begin
      sh  <= byte_val;
      cnt <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         fall,
  input  logic [W-1:0] src,
  output logic         so
);

  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
      so  <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
    end else if (fall) begin
      if (cnt == '0) begin
        so <= src[W-1];
        sh <= {src[W-2:0], 1'b0};
      end else begin
        so <= sh[W-1];
        sh <= {sh[W-2:0], 1'b0};
      end
      cnt <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
    end
  end

  // R4: the output bit only moves on a detected falling edge
  a_r4_so_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall) |-> $stable(so));

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int unsigned AW          = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              busy,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [AW-1:0]     prot_addr,
  input  logic              wr_permit,
  output logic              wen_set,
  output logic              wen_clr,
  input  logic [BYTE_W-1:0] status_in,
  output logic              sr_wr,
  output logic [BYTE_W-1:0] sr_wdata
);

  localparam int unsigned ADDR_BYTES = (AW + BYTE_W - 1) / BYTE_W;
  localparam int unsigned ACC_W      = AW - BYTE_W;
  localparam int unsigned AC_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic sck_rise, sck_fall, cs_active, cs_end, si_s;
  logic byte_done;
  logic [BYTE_W-1:0] byte_val;

  phase_t            phase;
  logic [BYTE_W-1:0] opc;
  logic [ACC_W-1:0]  acc;
  logic [AC_W-1:0]   acnt;
  logic [AW-1:0]     ptr;
  logic [AW-1:0]     full_addr;
  logic              tx_en;
  logic [BYTE_W-1:0] tx_src;
  logic              so_bit;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active),
    .cs_end(cs_end), .si_s(si_s)
  );

  spi_rx_shifter #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(!cs_active), .shift(sck_rise),
    .bit_in(si_s), .byte_done(byte_done), .byte_val(byte_val)
  );

  assign tx_en  = cs_active && (phase == PH_RDATA || phase == PH_SRD);
  assign tx_src = (phase == PH_SRD) ? status_in : mem_rdata;

  spi_tx_shifter #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(!tx_en), .fall(sck_fall),
    .src(tx_src), .so(so_bit)
  );

  assign spi_so    = so_bit;
  assign spi_so_oe = tx_en;
  assign full_addr = {acc, byte_val};
  assign prot_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OPC;
      opc       <= '0;
      acc       <= '0;
      acnt      <= '0;
      ptr       <= '0;
      mem_addr  <= '0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      wen_set   <= 1'b0;
      wen_clr   <= 1'b0;
      sr_wr     <= 1'b0;
      sr_wdata  <= '0;
    end else begin
      mem_re  <= 1'b0;
      mem_we  <= 1'b0;
      wen_set <= 1'b0;
      wen_clr <= 1'b0;
      sr_wr   <= 1'b0;
      if (!cs_active) begin
        if (cs_end && phase == PH_CMD) begin
          wen_set <= (opc == OPC_WREN);
          wen_clr <= (opc == OPC_WRDI);
        end
        phase <= PH_OPC;
        acnt  <= '0;
      end else if (byte_done) begin
        case (phase)
          PH_OPC: begin
            opc <= byte_val;
            case (byte_val)
              OPC_READ, OPC_WRITE: phase <= busy ? PH_SKIP : PH_ADDR;
              OPC_WREN, OPC_WRDI:  phase <= PH_CMD;
              OPC_RDSR:            phase <= PH_SRD;
              OPC_WRSR:            phase <= PH_SWR;
              default:             phase <= PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            acc  <= full_addr[ACC_W-1:0];
            acnt <= acnt + 1'b1;
            if (acnt == AC_W'(ADDR_BYTES - 1)) begin
              if (opc == OPC_READ) begin
                mem_addr <= full_addr;
                mem_re   <= 1'b1;
                ptr      <= full_addr + AW'(1);
                phase    <= PH_RDATA;
              end else begin
                ptr   <= full_addr;
                phase <= PH_WDATA;
              end
            end
          end
          PH_RDATA: begin
            mem_addr <= ptr;
            mem_re   <= 1'b1;
            ptr      <= ptr + AW'(1);
          end
          PH_WDATA: begin
            mem_addr  <= ptr;
            mem_wdata <= byte_val;
            mem_we    <= wr_permit && !busy;
            ptr       <= ptr + AW'(1);
          end
          PH_SWR: begin
            sr_wr    <= 1'b1;
            sr_wdata <= byte_val;
            phase    <= PH_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // R6: reads and writes never share a cycle
  a_r6_we_re_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R7: a write strobe needs permission, and no busy, in the deciding cycle
  a_r7_we_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wr_permit && !busy));

  // R9: a write strobe only follows a cycle inside an open frame
  a_r9_we_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(cs_active));

  // R2: latch set and clear never fire together
  a_r2_wen_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wen_set && wen_clr));

  // R11: the status write pulse lasts one cycle
  a_r11_sr_single: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |=> !sr_wr);

  // R5: read strobes are single-cycle
  a_r5_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

endmodule

// File: tb/spi_burst_engine_test.sv
module spi_burst_engine_test;

  localparam int MASK = 32'h1FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_si = 1'b0;
  logic busy = 1'b0;
  logic spi_so, spi_so_oe;
  logic [16:0] mem_addr, prot_addr;
  logic mem_re, mem_we, wen_set, wen_clr, sr_wr, wr_permit;
  logic [7:0] mem_wdata, sr_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] status_in = 8'hA5;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0, re_cnt = 0, ws_cnt = 0, wc_cnt = 0, sr_cnt = 0, oe_cnt = 0;
  logic [7:0] sr_last = 8'h00;
  int bp_lvl = 0;
  logic wen_m = 1'b0;
  bit wen_exp = 1'b0;

  logic [7:0] mem  [int];
  logic [7:0] expm [int];

  always #5 clk = ~clk;

  spi_burst_engine uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe), .busy(busy),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .prot_addr(prot_addr),
    .wr_permit(wr_permit), .wen_set(wen_set), .wen_clr(wen_clr),
    .status_in(status_in), .sr_wr(sr_wr), .sr_wdata(sr_wdata)
  );

  function automatic logic [7:0] seed_val(int a);
    return 8'((a * 13) ^ (a >> 9));
  endfunction

  function automatic logic [7:0] mem_get(int a);
    if (mem.exists(a)) return mem[a];
    return seed_val(a);
  endfunction

  function automatic logic [7:0] exp_get(int a);
    if (expm.exists(a)) return expm[a];
    return seed_val(a);
  endfunction

  function automatic bit prot_hit(int a, int lvl);
    case (lvl)
      1: return a >= 32'h18000;
      2: return a >= 32'h10000;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assign wr_permit = wen_m && !prot_hit(int'(prot_addr), bp_lvl);

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem_get(int'(mem_addr));
  end

  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
  end

  always @(posedge clk) begin
    if (wen_set) wen_m <= 1'b1;
    else if (wen_clr) wen_m <= 1'b0;
  end

  always @(posedge clk) begin
    if (mem_we) we_cnt++;
    if (mem_re) re_cnt++;
    if (wen_set) ws_cnt++;
    if (wen_clr) wc_cnt++;
    if (spi_so_oe) oe_cnt++;
    if (sr_wr) begin
      sr_cnt++;
      sr_last = sr_wdata;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic sbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nb; i--) begin
      spi_si = tx[i];
      #40;
      rx[i] = spi_so;
      spi_sck = 1'b1;
      #40;
      spi_sck = 1'b0;
    end
  endtask

  task automatic sbyte(input logic [7:0] tx);
    logic [7:0] dummy;
    sbits(tx, 8, dummy);
  endtask

  task automatic fbegin();
    spi_cs_n = 1'b0;
    #40;
  endtask

  task automatic fend();
    #40;
    spi_cs_n = 1'b1;
    #120;
  endtask

  task automatic send_addr(int a);
    logic [7:0] hi;
    hi = (8'($urandom) & 8'hFE) | {7'd0, a[16]};
    sbyte(hi);
    sbyte(a[15:8]);
    sbyte(a[7:0]);
  endtask

  task automatic send_cmd(logic [7:0] op);
    fbegin();
    sbyte(op);
    fend();
  endtask

  task automatic do_write(int a, int n, string tag);
    logic [7:0] d;
    int aa;
    fbegin();
    sbyte(8'h02);
    send_addr(a);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sbyte(d);
      aa = (a + k) & MASK;
      if (wen_exp && !prot_hit(aa, bp_lvl) && !busy) expm[aa] = d;
    end
    fend();
    for (int k = 0; k < n; k++) begin
      aa = (a + k) & MASK;
      chk(mem_get(aa) == exp_get(aa), tag, int'(mem_get(aa)), int'(exp_get(aa)));
    end
  endtask

  task automatic do_read(int a, int n, string tag);
    logic [7:0] rx;
    int aa;
    fbegin();
    sbyte(8'h03);
    send_addr(a);
    for (int k = 0; k < n; k++) begin
      sbits(8'($urandom), 8, rx);
      aa = (a + k) & MASK;
      chk(rx == exp_get(aa), tag, int'(rx), int'(exp_get(aa)));
    end
    fend();
  endtask

  initial begin
    #1_800_000;
    errors++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0, r0, o0, s0, c0, ws0, wc0;
    logic [7:0] rx;
    void'($urandom(32'd20240));
    #100;
    rst_n = 1'b1;
    #20;

    // R1: idle outputs after reset
    chk(spi_so_oe == 1'b0, "R1 so_oe", int'(spi_so_oe), 0);
    chk(mem_we == 1'b0 && mem_re == 1'b0, "R1 strobes", int'({mem_we, mem_re}), 0);
    chk({wen_set, wen_clr, sr_wr} == 3'b000, "R1 pulses", int'({wen_set, wen_clr, sr_wr}), 0);

    // R2: set write latch
    ws0 = ws_cnt;
    send_cmd(8'h06);
    wen_exp = 1'b1;
    chk(ws_cnt == ws0 + 1, "R2 wen_set", ws_cnt, ws0 + 1);

    // R3 / R4: reads with random junk in the upper bits of the first address byte
    do_read(32'h1ABCD, 4, "R4 read");
    do_read(32'h00123, 2, "R3 addr");

    // R5: read burst wraps at the top
    do_read(32'h1FFFE, 4, "R5 wrap");

    // R6: write bursts, plain and wrapping
    do_write(32'h04567, 5, "R6 write");
    do_read(32'h04567, 5, "R6 readback");
    do_write(32'h1FFFF, 3, "R6 wrap");
    do_read(32'h1FFFF, 3, "R6 wrap readback");

    // R7: protected top quarter, crossing into it
    bp_lvl = 1;
    w0 = we_cnt;
    do_write(32'h17FFE, 4, "R7 cross");
    chk(we_cnt == w0 + 2, "R7 strobes cross", we_cnt - w0, 2);
    // R7 with wrap: refusal at 0x1FFFF and acceptance at 0 in adjacent bytes
    w0 = we_cnt;
    do_write(32'h1FFFE, 4, "R7 wrap");
    chk(we_cnt == w0 + 2, "R7 strobes wrap", we_cnt - w0, 2);
    do_read(32'h1FFFE, 4, "R7 wrap readback");
    bp_lvl = 0;

    // R8: busy refuses array commands
    busy = 1'b1;
    w0 = we_cnt; r0 = re_cnt; o0 = oe_cnt;
    do_write(32'h00200, 3, "R8 write");
    chk(we_cnt == w0, "R8 no we", we_cnt - w0, 0);
    fbegin();
    sbyte(8'h03);
    send_addr(32'h00200);
    sbyte(8'h00);
    sbyte(8'h00);
    fend();
    chk(re_cnt == r0, "R8 no re", re_cnt - r0, 0);
    chk(oe_cnt == o0, "R8 no so", oe_cnt - o0, 0);
    busy = 1'b0;

    // R9: partial trailing byte discarded
    w0 = we_cnt;
    fbegin();
    sbyte(8'h02);
    send_addr(32'h00300);
    sbyte(8'h5A);
    sbits(8'hC3, 5, rx);
    fend();
    expm[32'h300] = 8'h5A;
    chk(we_cnt == w0 + 1, "R9 strobes", we_cnt - w0, 1);
    chk(mem_get(32'h300) == 8'h5A, "R9 full byte", int'(mem_get(32'h300)), 8'h5A);
    chk(mem_get(32'h301) == exp_get(32'h301), "R9 partial", int'(mem_get(32'h301)), int'(exp_get(32'h301)));

    // R10: unknown command is inert
    w0 = we_cnt; r0 = re_cnt; o0 = oe_cnt; s0 = sr_cnt; ws0 = ws_cnt; wc0 = wc_cnt;
    fbegin();
    sbyte(8'hAB);
    sbyte(8'h01);
    sbyte(8'h02);
    sbyte(8'h03);
    fend();
    chk(we_cnt == w0 && re_cnt == r0, "R10 strobes", (we_cnt - w0) + (re_cnt - r0), 0);
    chk(oe_cnt == o0, "R10 so", oe_cnt - o0, 0);
    chk(sr_cnt == s0 && ws_cnt == ws0 && wc_cnt == wc0, "R10 pulses",
        (sr_cnt - s0) + (ws_cnt - ws0) + (wc_cnt - wc0), 0);

    // R11: status read resamples per byte
    status_in = 8'hA5;
    fbegin();
    sbyte(8'h05);
    sbits(8'h00, 8, rx);
    chk(rx == 8'hA5, "R11 status byte0", int'(rx), 8'hA5);
    status_in = 8'h5E;
    sbits(8'h00, 8, rx);
    chk(rx == 8'h5E, "R11 status byte1", int'(rx), 8'h5E);
    fend();

    // R11: status write keeps first byte only
    s0 = sr_cnt;
    fbegin();
    sbyte(8'h01);
    sbyte(8'h3C);
    sbyte(8'h99);
    fend();
    chk(sr_cnt == s0 + 1, "R11 sr pulses", sr_cnt - s0, 1);
    chk(sr_last == 8'h3C, "R11 sr data", int'(sr_last), 8'h3C);

    // R2: clear write latch, SO idle
    c0 = wc_cnt; o0 = oe_cnt;
    send_cmd(8'h04);
    wen_exp = 1'b0;
    chk(wc_cnt == c0 + 1, "R2 wen_clr", wc_cnt - c0, 1);
    chk(oe_cnt == o0, "R2 so idle", oe_cnt - o0, 0);

    // R7: latch clear denies writes
    w0 = we_cnt;
    do_write(32'h00500, 2, "R7 latch off");
    chk(we_cnt == w0, "R7 no we latch off", we_cnt - w0, 0);

    // Random bursts: R5 / R6 / R7
    send_cmd(8'h06);
    wen_exp = 1'b1;
    for (int it = 0; it < 8; it++) begin
      int a, n;
      bp_lvl = int'($urandom % 4);
      a = int'($urandom) & MASK;
      n = 1 + int'($urandom % 6);
      do_write(a, n, "R6 random write");
      do_read(a, n, "R5 random read");
    end
    bp_lvl = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule